// File: doc/BRIEF.md
# Synchronous slave serial transmitter

This block sends words over a clocked serial link on which another device is the clock master. The remote master drives the shift clock into `ext_clk`. The transmitter returns one data bit per clock period on `ser_out`, least significant bit first. A new bit is presented after each falling edge, so the master can sample on the rising edge. The link clock is taken into the system clock domain through a two-flop synchroniser and a falling-edge detector. The system clock must run at least four times faster than the link clock.

Software or a local controller writes words through a one-word holding register. That register feeds a shift register, which gives double buffering. A word written while the shifter is idle goes straight into the shifter. A word written while a transfer is running waits in the holding register. It moves across when the running word has shifted its last bit. `buf_empty` reports whether the holding register can take another word, and `irq` raises a request when it can and the interrupt is enabled. An optional ninth bit is taken from `bit9_in` when the word is written. The transmitter runs only when it is configured as a synchronous slave with the port on, both receive enables off and the transmit enable set.

Top module: `sync_slave_tx`

## Requirements
- R1: After reset `ser_out` is 1, `buf_empty` is 1 and `irq` is 0 while `int_en` is 0.
- R2: An 8-bit word is sent least significant bit first. Bit k appears on `ser_out` after the (k+1)-th falling edge of `ext_clk` that follows the write into an idle shifter. `ser_out` changes only after a synchronised falling edge, or when the transmitter is disabled. After the falling edge that follows the last bit, `ser_out` returns to 1 if no word is waiting.
- R3: When `nine_bit_en` is 1 at the write, the word has nine bits. The ninth bit sent is the value `bit9_in` had at the write.
- R4: A word written while both the shifter and the holding register are empty goes straight into the shifter, and `buf_empty` stays 1.
- R5: A word written while the shifter is busy and the holding register is empty is kept in the holding register, and `buf_empty` reads 0 until that word is handed over.
- R6: On the falling edge that ends the last bit of the running word, a waiting word is handed over. Its bit 0 appears on `ser_out` after that same edge, with no idle bit in between, and `buf_empty` returns to 1.
- R7: `irq` is 1 exactly when `buf_empty` is 1 and `int_en` is 1.
- R8: A write is ignored unless `port_en`=1, `sync_mode`=1, `clk_src_master`=0, `rx_single_en`=0, `rx_cont_en`=0 and `tx_en`=1.
- R9: When the transmitter leaves the enabled state of R8 (for example when `tx_en` is cleared), any shift in progress stops. Both registers are emptied, `ser_out` goes to 1 and `buf_empty` goes to 1. Enabling it again sends nothing from before.
- R10: A write while the holding register is full and not being handed over in that cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_en | input | 1 | Serial port enable |
| sync_mode | input | 1 | Synchronous mode select |
| clk_src_master | input | 1 | Clock source select; 0 selects slave (external clock) |
| rx_single_en | input | 1 | Single receive enable; must be 0 to transmit |
| rx_cont_en | input | 1 | Continuous receive enable; must be 0 to transmit |
| tx_en | input | 1 | Transmit enable |
| nine_bit_en | input | 1 | Nine-bit word select, taken at write |
| bit9_in | input | 1 | Ninth data bit, taken at write |
| int_en | input | 1 | Transmit interrupt enable |
| wr_valid | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Data word to write |
| ext_clk | input | 1 | Shift clock from the remote master |
| ser_out | output | 1 | Serial data output, idle high |
| buf_empty | output | 1 | Holding register empty flag |
| irq | output | 1 | Transmit interrupt request |

## Verification
A lone 8-bit word into an idle shifter, 0xA5, shows bit order and that the line idles after the last bit. A nine-bit word then shows the ninth bit's source. Two words written close together show the holding path and the gapless hand-off. A third write into a full buffer, 0x00 data, must leave no trace, which separates dropping from overwriting. All-zero words written while one enable condition is wrong, or aborted mid-shift, make any leaked or resumed bit visible against the idle-high line.

// File: rtl/sstx_pkg.sv
// Package: shared types for the synchronous slave transmitter.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package sstx_pkg;

    // Source of the word loaded into the shift register in a cycle.
    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_HOLD  = 2'd1,
        SRC_WRITE = 2'd2
    } load_src_e;

    // Default payload width of one word, without the optional ninth bit.
    localparam int SSTX_DATA_W = 8;

endpackage

// File: rtl/sstx_edge_sync.sv
// Brings the remote shift clock into the system clock domain and emits a
// one-cycle pulse for each falling edge. Assumes the system clock is at
// least four times the shift clock, so no edge is missed.
module sstx_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_clk,
    output logic fall_o
);

    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Synchroniser chain plus one delay flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], ext_clk};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign fall_o = prev_q & ~sync_q[STAGES-1];

endmodule

// File: rtl/sstx_hold.sv
// One-word holding register in front of the shifter. It keeps the word and
// its length flag until the controller takes it. A write into a full
// register that is not being emptied in the same cycle is dropped.
module sstx_hold #(
    parameter int DATA_W = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          wr,
    input  logic [DATA_W:0] wr_word,
    input  logic          wr_ninth,
    input  logic          take,
    output logic          full_o,
    output logic [DATA_W:0] word_o,
    output logic          ninth_o
);

    logic            full_q;
    logic [DATA_W:0] word_q;
    logic            ninth_q;

    // Occupancy flag: set by write, cleared by take or abort.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            full_q <= 1'b0;
        end else if (wr) begin
            full_q <= 1'b1;
        end else if (take) begin
            full_q <= 1'b0;
        end
    end

    // Payload capture on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q  <= '0;
            ninth_q <= 1'b0;
        end else if (wr) begin
            word_q  <= wr_word;
            ninth_q <= wr_ninth;
        end
    end

    assign full_o  = full_q;
    assign word_o  = word_q;
    assign ninth_o = ninth_q;

endmodule

// File: rtl/sstx_shifter.sv
// Transmit shift register. Presents one bit per falling edge of the shift
// clock, least significant first, and holds the line high when idle.
// need_o marks a cycle in which it can take a word: either idle, or on the
// falling edge that ends the last bit. A word loaded on that edge presents
// its bit 0 at once; a word loaded while idle waits for the next edge.
module sstx_shifter #(
    parameter int DATA_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            fall,
    input  logic            load,
    input  logic [DATA_W:0] ld_word,
    input  logic            ld_ninth,
    output logic            busy_o,
    output logic            need_o,
    output logic            ser_o
);

    localparam int CW = $clog2(DATA_W + 2);

    logic            busy_q;
    logic            out_q;
    logic [DATA_W:0] sh_q;
    logic [CW-1:0]   left_q;
    logic [CW-1:0]   ld_bits;
    logic            finishing;

    assign ld_bits   = ld_ninth ? CW'(DATA_W + 1) : CW'(DATA_W);
    assign finishing = busy_q & fall & (left_q == '0);

    // Shift state: load, present the next bit on each falling edge, retire.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            busy_q <= 1'b0;
            out_q  <= 1'b1;
            sh_q   <= '0;
            left_q <= '0;
        end else if (load && finishing) begin
            out_q  <= ld_word[0];
            sh_q   <= ld_word >> 1;
            left_q <= ld_bits - 1'b1;
        end else if (load) begin
            busy_q <= 1'b1;
            sh_q   <= ld_word;
            left_q <= ld_bits;
        end else if (finishing) begin
            busy_q <= 1'b0;
            out_q  <= 1'b1;
        end else if (busy_q && fall) begin
            out_q  <= sh_q[0];
            sh_q   <= sh_q >> 1;
            left_q <= left_q - 1'b1;
        end
    end

    assign busy_o = busy_q;
    assign need_o = ~busy_q | finishing;
    assign ser_o  = out_q;

endmodule

// File: rtl/sync_slave_tx.sv
// Synchronous slave serial transmitter top. Decodes the enable conditions,
// routes writes either straight into an idle shifter or into the holding
// register, hands a waiting word over when the shifter ends a word, and
// derives the empty flag and interrupt request. Assumes ext_clk is at most
// a quarter of the clk rate.
module sync_slave_tx #(
    parameter int DATA_W    = sstx_pkg::SSTX_DATA_W,
    parameter int SYNC_STGS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_en,
    input  logic              sync_mode,
    input  logic              clk_src_master,
    input  logic              rx_single_en,
    input  logic              rx_cont_en,
    input  logic              tx_en,
    input  logic              nine_bit_en,
    input  logic              bit9_in,
    input  logic              int_en,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ext_clk,
    output logic              ser_out,
    output logic              buf_empty,
    output logic              irq
);

    import sstx_pkg::*;

    logic            active;
    logic            wr_ok;
    logic            ext_fall;
    logic            hold_full;
    logic [DATA_W:0] hold_word;
    logic            hold_ninth;
    logic            hold_take;
    logic            hold_wr;
    logic            sh_busy;
    logic            sh_need;
    logic            sh_load;
    logic [DATA_W:0] sh_word;
    logic            sh_ninth;
    logic [DATA_W:0] wr_word;
    load_src_e       src;

    // Enable decode: slave synchronous transmit with receive off.
    assign active = port_en & sync_mode & ~clk_src_master &
                    ~rx_single_en & ~rx_cont_en & tx_en;
    assign wr_ok  = wr_valid & active;
    assign wr_word = {bit9_in & nine_bit_en, wr_data};

    sstx_edge_sync #(.STAGES(SYNC_STGS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .ext_clk (ext_clk),
        .fall_o  (ext_fall)
    );

    // Load source select: waiting word first, then a direct write to idle.
    always_comb begin
        if (hold_full && sh_need) begin
            src = SRC_HOLD;
        end else if (wr_ok && !sh_busy && !hold_full) begin
            src = SRC_WRITE;
        end else begin
            src = SRC_NONE;
        end
    end

    assign hold_take = (src == SRC_HOLD);
    assign hold_wr   = wr_ok & (src != SRC_WRITE) & (~hold_full | hold_take);
    assign sh_load   = (src != SRC_NONE);
    assign sh_word   = (src == SRC_HOLD) ? hold_word : wr_word;
    assign sh_ninth  = (src == SRC_HOLD) ? hold_ninth : nine_bit_en;

    sstx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (~active),
        .wr       (hold_wr),
        .wr_word  (wr_word),
        .wr_ninth (nine_bit_en),
        .take     (hold_take),
        .full_o   (hold_full),
        .word_o   (hold_word),
        .ninth_o  (hold_ninth)
    );

    sstx_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (~active),
        .fall     (ext_fall),
        .load     (sh_load),
        .ld_word  (sh_word),
        .ld_ninth (sh_ninth),
        .busy_o   (sh_busy),
        .need_o   (sh_need),
        .ser_o    (ser_out)
    );

    // Flag and interrupt request from holding register occupancy.
    assign buf_empty = ~hold_full;
    assign irq       = ~hold_full & int_en;

endmodule

// File: rtl/sstx_checks.sv
// Property checker for sync_slave_tx, attached by bind. Observes the
// enable decode, the synchronised edge pulse and the hand-off strobe.
module sstx_checks (
    input logic clk,
    input logic rst_n,
    input logic active,
    input logic fall,
    input logic hold_take,
    input logic int_en,
    input logic ser_out,
    input logic buf_empty,
    input logic irq
);

    // R2: while enabled, the line moves only after a falling edge pulse.
    assert_out_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(active) && !$stable(ser_out)) |-> $past(fall));

    // R2: the edge detector gives single-cycle pulses.
    assert_fall_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);

    // R5: a waiting word stays until handed over.
    assert_hold_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !buf_empty && !hold_take) |=> !buf_empty);

    // R7: a new request needs the enable and an empty buffer.
    assert_irq_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (int_en && buf_empty));

    // R9: disabling empties the buffer and idles the line.
    assert_disabled_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (ser_out && buf_empty));

endmodule

bind sync_slave_tx sstx_checks u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (active),
    .fall      (ext_fall),
    .hold_take (hold_take),
    .int_en    (int_en),
    .ser_out   (ser_out),
    .buf_empty (buf_empty),
    .irq       (irq)
);

// File: tb/sync_slave_tx_test.sv
module sync_slave_tx_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       port_en = 1'b0, sync_mode = 1'b0, clk_src_master = 1'b0;
    logic       rx_single_en = 1'b0, rx_cont_en = 1'b0, tx_en = 1'b0;
    logic       nine_bit_en = 1'b0, bit9_in = 1'b0, int_en = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       ext_clk = 1'b1;
    logic       ser_out, buf_empty, irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sync_slave_tx uut (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .sync_mode(sync_mode),
        .clk_src_master(clk_src_master), .rx_single_en(rx_single_en),
        .rx_cont_en(rx_cont_en), .tx_en(tx_en), .nine_bit_en(nine_bit_en),
        .bit9_in(bit9_in), .int_en(int_en), .wr_valid(wr_valid),
        .wr_data(wr_data), .ext_clk(ext_clk), .ser_out(ser_out),
        .buf_empty(buf_empty), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One shift clock period: fall, let the bit settle, sample, rise.
    task automatic ext_bit(output logic b);
        ext_clk = 1'b0;
        idle_clks(8);
        b = ser_out;
        ext_clk = 1'b1;
        idle_clks(8);
    endtask

    task automatic write_word(input logic [7:0] d);
        wr_data  = d;
        wr_valid = 1'b1;
        idle_clks(1);
        wr_valid = 1'b0;
    endtask

    task automatic enable_all();
        port_en = 1'b1; sync_mode = 1'b1; clk_src_master = 1'b0;
        rx_single_en = 1'b0; rx_cont_en = 1'b0; tx_en = 1'b1;
        idle_clks(2);
    endtask

    task automatic expect_bits(input string req, input logic [8:0] w, input int n);
        logic b;
        for (int i = 0; i < n; i++) begin
            ext_bit(b);
            check(req, b, w[i]);
        end
    endtask

    task automatic t_reset();
        check("R1 ser_out", ser_out, 1);
        check("R1 buf_empty", buf_empty, 1);
        check("R1 irq", irq, 0);
    endtask

    task automatic t_single();
        logic b;
        enable_all();
        write_word(8'hA5);
        idle_clks(2);
        check("R4 buf_empty after direct load", buf_empty, 1);
        check("R2 line idle before first fall", ser_out, 1);
        expect_bits("R2 lsb-first bit", 9'h0A5, 8);
        ext_bit(b);
        check("R2 idle after last bit", b, 1);
    endtask

    task automatic t_nine();
        logic b;
        nine_bit_en = 1'b1; bit9_in = 1'b1;
        write_word(8'h3C);
        bit9_in = 1'b0;
        expect_bits("R3 nine-bit word", 9'h13C, 9);
        ext_bit(b);
        check("R3 idle after ninth bit", b, 1);
        nine_bit_en = 1'b0;
    endtask

    task automatic t_back2back();
        logic b;
        int_en = 1'b1;
        idle_clks(1);
        check("R7 irq with empty buffer", irq, 1);
        write_word(8'h81);
        idle_clks(2);
        write_word(8'h5E);
        idle_clks(2);
        check("R5 buf_empty while word waits", buf_empty, 0);
        check("R7 irq low while full", irq, 0);
        expect_bits("R5 first word", 9'h081, 8);
        check("R5 still waiting before hand-off", buf_empty, 0);
        ext_bit(b);
        check("R6 bit0 of second word at hand-off", b, 0);
        check("R6 buf_empty after hand-off", buf_empty, 1);
        check("R7 irq after hand-off", irq, 1);
        expect_bits("R6 rest of second word", 9'h05E >> 1, 7);
        ext_bit(b);
        check("R6 idle after second word", b, 1);
        int_en = 1'b0;
        idle_clks(1);
        check("R7 irq off with enable off", irq, 0);
    endtask

    task automatic t_drop();
        logic b;
        write_word(8'hF0);
        idle_clks(2);
        write_word(8'h0F);
        idle_clks(2);
        write_word(8'h00);
        expect_bits("R10 first word", 9'h0F0, 8);
        expect_bits("R10 second word kept", 9'h00F, 8);
        ext_bit(b);
        check("R10 third word dropped", b, 1);
        check("R10 buf_empty", buf_empty, 1);
    endtask

    task automatic t_gate();
        logic b;
        rx_cont_en = 1'b1;
        idle_clks(2);
        write_word(8'h00);
        idle_clks(2);
        check("R8 buf_empty with receive on", buf_empty, 1);
        for (int i = 0; i < 9; i++) begin
            ext_bit(b);
            check("R8 no output with receive on", b, 1);
        end
        rx_cont_en = 1'b0; clk_src_master = 1'b1;
        idle_clks(2);
        write_word(8'h00);
        clk_src_master = 1'b0;
        idle_clks(2);
        for (int i = 0; i < 9; i++) begin
            ext_bit(b);
            check("R8 no output from master-mode write", b, 1);
        end
    endtask

    task automatic t_abort();
        logic b;
        write_word(8'h00);
        expect_bits("R9 bits before abort", 9'h000, 3);
        write_word(8'h00);
        idle_clks(2);
        check("R9 second word waiting", buf_empty, 0);
        check("R9 line low mid-word", ser_out, 0);
        tx_en = 1'b0;
        idle_clks(2);
        check("R9 line idle after abort", ser_out, 1);
        check("R9 buf_empty after abort", buf_empty, 1);
        tx_en = 1'b1;
        idle_clks(2);
        for (int i = 0; i < 10; i++) begin
            ext_bit(b);
            check("R9 nothing resumes", b, 1);
        end
    endtask

    initial begin
        idle_clks(4);
        rst_n = 1'b1;
        idle_clks(2);
        t_reset();
        t_single();
        t_nine();
        t_back2back();
        t_drop();
        t_gate();
        t_abort();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule